// File: doc/BRIEF.md
# Storage-Card Host Interrupt Status Block

This block gathers 32 event flags from the command and data engines of a storage-card host controller and turns them into a single interrupt request. Each engine reports an event as a one-cycle pulse on its bit of `evt_set_i`. The pulse latches a sticky flag in a raw status word. Software sees and controls the flags through a small word-addressed register port.

Two programmable words act as filters. The visibility mask decides which latched flags software can read. The drive-enable word decides which of those visible flags may raise `irq_o`. Three sources are reserved and can never raise the line: DMA done (bit 3), card insertion (bit 6) and card removal (bit 7).

Bits 31:16 are error flags. Bit 15 summarises them and always equals the OR of bits 31:16. After power-up, the card-insertion flag is already set. It stays set until software writes the clock-control word with its reset-all request bit set.

Top module: `sdirq_top`

## Requirements
- R1: A read at word address 0 returns the raw status ANDed with the visibility mask, so a latched flag whose mask bit is 0 reads as 0.
- R2: `irq_o` is high exactly when the AND of raw status, mask, enable and the inverted reserved set is nonzero. It follows any change of status, mask or enable in the cycle after the write or pulse that made the change.
- R3: Status bits 3, 6 and 7 never drive `irq_o`, even when they are latched, masked in and enabled.
- R4: Writing word address 0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R5: Status bit 15 equals the OR of bits 31:16 at every clock. A pulse on any of bits 31:16 sets bit 15 at the same edge. Clearing the last remaining error bit also clears bit 15, and writing a 1 to bit 15 alone has no effect while any error bit is still set.
- R6: After reset the status word holds only bit 6 (value 0x00000040), and the mask, enable and clock-control words read as 0.
- R7: A write to word address 3 (clock control) with data bit 24 set clears status bit 6. A write to that address without bit 24 set leaves bit 6 unchanged. Data bits 26:24 are never stored and always read back as 0. Every other bit of that write is stored and read back.
- R8: When an event pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R9: Word address 1 (mask) and word address 2 (enable) store the full written word and read it back.
- R10: A latched status bit holds its value until it is cleared. A pulse on `evt_set_i[15]` has no effect of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_set_i | input | 32 | One-cycle event pulses, one per status bit |
| bus_we_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | 2 | Word address: 0 status, 1 mask, 2 enable, 3 clock control |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the word at `bus_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets five corner cases, each named with the faulty behaviour it would catch.

- **Reserved sources:** with bits 3, 6 and 7 latched, masked in and enabled, a design that forgets the reserved set would raise `irq_o`.
- **Error summary:** the bench sets two error bits and clears them one at a time, and also writes bit 15 alone. A summary computed from the wrong range, or cleared while an error bit remains, would show up on the status read.
- **Set against clear:** the bench pulses and clears the same bit in the same cycle. A design that gives the clear priority would lose the event.
- **Clock-control write:** the bench checks that only a write with bit 24 set removes the card-insertion flag, and that the request bits never read back. A design that stores the request bits, or that clears bit 6 on any write to that word, would fail here.
- **Random traffic:** a long random run mixes pulses with writes to every address, to catch mask and enable interactions the directed cases miss.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned CARD_IN_B = 6;
  localparam int unsigned ERR_SUM_B = 15;
  localparam int unsigned ERR_LO_B  = 16;
  localparam int unsigned RST_ALL_B = 24;

  localparam logic [DATA_W-1:0] RSV_MASK  = (DATA_W'(1) << 3) | (DATA_W'(1) << 6) | (DATA_W'(1) << 7);
  localparam logic [DATA_W-1:0] SUM_MASK  = DATA_W'(1) << ERR_SUM_B;
  localparam logic [DATA_W-1:0] CARD_MASK = DATA_W'(1) << CARD_IN_B;
  localparam logic [DATA_W-1:0] RSTQ_MASK = DATA_W'(7) << RST_ALL_B;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_MASK   = 2'd1,
    A_ENABLE = 2'd2,
    A_CLKCTL = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sdirq_status.sv
module sdirq_status
  import sdirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] raw_o
);
  logic [DATA_W-1:0] raw_q, upd, raw_d;

  // set has priority over clear; summary bit is recomputed, never latched
  always_comb begin
    upd   = (raw_q & ~clr_i) | set_i;
    raw_d = upd;
    raw_d[ERR_SUM_B] = |upd[DATA_W-1:ERR_LO_B];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= CARD_MASK;
    else         raw_q <= raw_d;
  end

  assign raw_o = raw_q;

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(set_i) & ~SUM_MASK) == ($past(set_i) & ~SUM_MASK)));

  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(clr_i & ~set_i) & ~SUM_MASK) == '0));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((raw_q ^ $past(raw_q)) & ~$past(set_i | clr_i) & ~SUM_MASK) == '0));

  p_sum_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i[DATA_W-1:ERR_LO_B]) |=> raw_q[ERR_SUM_B]);
endmodule

// File: rtl/sdirq_regs.sv
module sdirq_regs
  import sdirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] en_o,
  output logic [DATA_W-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mask_q, en_q, clk_q;
  reg_addr_e         a;

  assign a = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= '0;
      clk_q  <= '0;
    end else if (we_i) begin
      case (a)
        A_MASK:   mask_q <= wdata_i;
        A_ENABLE: en_q   <= wdata_i;
        A_CLKCTL: clk_q  <= wdata_i & ~RSTQ_MASK;  // reset requests self-clear
        default:  ;
      endcase
    end
  end

  always_comb begin
    clr_o = '0;
    if (we_i && a == A_STATUS) clr_o = wdata_i;
    if (we_i && a == A_CLKCTL && wdata_i[RST_ALL_B]) clr_o[CARD_IN_B] = 1'b1;
  end

  always_comb begin
    case (a)
      A_STATUS: rdata_o = raw_i & mask_q;
      A_MASK:   rdata_o = mask_q;
      A_ENABLE: rdata_o = en_q;
      default:  rdata_o = clk_q;
    endcase
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;
endmodule

// File: rtl/sdirq_gate.sv
module sdirq_gate
  import sdirq_pkg::*;
(
  input  logic [DATA_W-1:0] raw_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] en_i,
  output logic              irq_o
);
  assign irq_o = |(raw_i & mask_i & en_i & ~RSV_MASK);
endmodule

// File: rtl/sdirq_top.sv
module sdirq_top
  import sdirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] evt_set_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] raw, mask, en, clr, set_eff;

  assign set_eff = evt_set_i & ~SUM_MASK;

  sdirq_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_eff), .clr_i(clr), .raw_o(raw)
  );

  sdirq_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .raw_i(raw), .mask_o(mask), .en_o(en),
    .clr_o(clr), .rdata_o(bus_rdata_o)
  );

  sdirq_gate u_gate (
    .raw_i(raw), .mask_i(mask), .en_i(en), .irq_o(irq_o)
  );

  p_rsv_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw & ~RSV_MASK) == '0) |-> !irq_o);

  p_card_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_CLKCTL && bus_wdata_i[RST_ALL_B] && !evt_set_i[CARD_IN_B])
    |=> !raw[CARD_IN_B]);

  p_irq_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((mask & en) != '0));
endmodule

// File: tb/sdirq_top_bench.sv
`timescale 1ns/1ps
module sdirq_top_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] evt_set_i = '0;
  logic        bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  logic [31:0] m_raw, m_mask, m_en, m_clk;

  always #2.5 clk = ~clk;

  sdirq_top u_sdirq_top (
    .clk_i(clk), .rst_ni(rst_ni), .evt_set_i(evt_set_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_raw & m_mask;
      2'd1: return m_mask;
      2'd2: return m_en;
      default: return m_clk;
    endcase
  endfunction

  // drive at negedge, compare before the edge, advance the model after it
  task automatic step(bit we, logic [1:0] a, logic [31:0] d, logic [31:0] s, string tag);
    logic [31:0] clr;
    @(negedge clk);
    bus_we_i = we; bus_addr_i = a; bus_wdata_i = d; evt_set_i = s;
    #1;
    chk(tag, "rdata", bus_rdata_o, exp_read(a));
    chk(tag, "irq", {31'd0, irq_o}, {31'd0, |(m_raw & m_mask & m_en & ~32'h0000_00C8)});
    @(posedge clk);
    clr = '0;
    if (we && a == 2'd0) clr = d;
    if (we && a == 2'd3 && d[24]) clr[6] = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (s[i] && i != 15) m_raw[i] = 1'b1;
      else if (clr[i])     m_raw[i] = 1'b0;
    end
    m_raw[15] = (m_raw[31:16] != 16'd0);
    if (we && a == 2'd1) m_mask = d;
    if (we && a == 2'd2) m_en = d;
    if (we && a == 2'd3) m_clk = d & ~32'h0700_0000;
  endtask

  task automatic rd(logic [1:0] a, string tag);
    step(1'b0, a, 32'h0, 32'h0, tag);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
    step(1'b1, a, d, 32'h0, tag);
  endtask

  task automatic pulse(logic [31:0] s, string tag);
    step(1'b0, 2'd0, 32'h0, s, tag);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_raw = 32'h40; m_mask = '0; m_en = '0; m_clk = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R6 reset values
    rd(2'd0, "R6"); rd(2'd1, "R6"); rd(2'd2, "R6"); rd(2'd3, "R6");
    wr(2'd1, 32'hFFFF_FFFF, "R9");
    rd(2'd0, "R6");
    rd(2'd1, "R9");
    wr(2'd2, 32'hFFFF_FFFF, "R9");
    rd(2'd2, "R9");
    // R3 reserved sources latched but silent
    pulse(32'h0000_0088, "R3");
    rd(2'd0, "R3"); rd(2'd0, "R3");
    // R2 live source raises the line
    pulse(32'h0000_0001, "R2");
    rd(2'd0, "R2");
    wr(2'd1, 32'hFFFF_FFFE, "R1");
    rd(2'd0, "R1");
    wr(2'd2, 32'hFFFF_FFFE, "R2");
    wr(2'd1, 32'hFFFF_FFFF, "R2");
    rd(2'd0, "R2");
    wr(2'd2, 32'hFFFF_FFFF, "R2");
    rd(2'd0, "R2");
    // R4 write-one-to-clear, zeros untouched
    wr(2'd0, 32'h0000_0000, "R4");
    rd(2'd0, "R4");
    wr(2'd0, 32'h0000_0001, "R4");
    rd(2'd0, "R4");
    // R5 error summary
    pulse(32'h0002_0000, "R5");
    rd(2'd0, "R5");
    wr(2'd0, 32'h0000_8000, "R5");
    rd(2'd0, "R5");
    pulse(32'h0010_0000, "R5");
    wr(2'd0, 32'h0002_0000, "R5");
    rd(2'd0, "R5");
    wr(2'd0, 32'h0010_0000, "R5");
    rd(2'd0, "R5");
    // R10 pulse on the summary bit alone does nothing
    pulse(32'h0000_8000, "R10");
    rd(2'd0, "R10"); rd(2'd0, "R10");
    // R8 same-cycle set and clear
    step(1'b1, 2'd0, 32'h0000_0010, 32'h0000_0010, "R8");
    rd(2'd0, "R8");
    step(1'b1, 2'd0, 32'h0004_0000, 32'h0004_0000, "R8");
    rd(2'd0, "R8");
    wr(2'd0, 32'hFFFF_FFFF, "R4");
    rd(2'd0, "R4");
    // R7 clock-control behaviour
    pulse(32'h0000_0040, "R7");
    wr(2'd3, 32'h0200_00FF, "R7");
    rd(2'd0, "R7"); rd(2'd3, "R7");
    wr(2'd3, 32'h0700_1234, "R7");
    rd(2'd0, "R7"); rd(2'd3, "R7");
    // random traffic over all requirements
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] s, d;
      logic [1:0]  a;
      s = $urandom & $urandom & $urandom;
      d = $urandom;
      a = 2'($urandom);
      step(($urandom % 4) == 0, a, d, s, "R1/R2/R5 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule